// File: doc/BRIEF.md
# Colored Memory Access Checker

This block guards a line-organized memory behind a load/store port. Every 64-byte line carries a hidden 4-bit color. Each access pointer holds a color in its top nibble. The unit compares the pointer's color with the stored color of the addressed line. If the colors agree, the read or write completes with the usual one-cycle response. If they differ, the access is suppressed, an error response is returned, and a sticky trap is raised. The trap records the offending pointer, the line's color, the access direction and a cause code.

A separate privileged port recolors one line per cycle. An allocator uses it on free and on reallocation. After a line is recolored, stale pointers that still carry the old color are caught on their next use.

A global enable selects between checked mode and plain mode. In plain mode colors are ignored, but the top nibble of the pointer must be a sign-style pattern.

Top module: `tag_check_unit`

## Requirements
- R1: Each line has a 4-bit color, and all colors are 0 after reset. The pointer color is reqPtr[63:60]. The line index is reqPtr[LINE_IDX_BITS+5:6] and the byte offset is reqPtr[5:0]. The color bits never take part in addressing.
- R2: Every request cycle produces respValid exactly one cycle later, with no stall. A request that passes the checks has respErr=0.
- R3: With tagEnable=1, a request whose pointer color differs from the line color gets respErr=1. Its response data is 0, and if it is a write, memory is left unchanged.
- R4: With tagEnable=0, colors are not compared. A pointer whose top nibble is neither 4'h0 nor 4'hF is rejected with cause 2.
- R5: reqSize encodes 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. An access whose offset plus size exceeds 64 is rejected with cause 3.
- R6: Data is little-endian: byte k of reqWdata/respRdata maps to line byte offset+k. Read data is zero-extended above the access size, and write responses return 0 data.
- R7: A recolor on the tag-set port in one cycle governs requests from the next cycle on. A request in the same cycle still sees the old color.
- R8: On a fault while trapFlag is clear, the trap registers capture the full pointer, the line color, the write flag and the cause. The cause codes are 1 for a color mismatch, 2 for a bad top nibble and 3 for a line crossing. While trapFlag is set, later faults leave these registers unchanged.
- R9: trapFlag rises after a fault and stays set until trapClear is asserted. If a fault and trapClear fall in the same cycle, the fault wins and its details are captured.
- R10: Ordinary reads and writes touch only data bytes. A write never alters a line color.
- R11: Fault priority is bad top nibble, then line crossing, then color mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tagEnable | input | 1 | 1 = compare colors, 0 = plain mode |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code |
| reqPtr | input | 64 | Colored pointer |
| reqWdata | input | 64 | Write data, little-endian |
| respValid | output | 1 | Response for the previous cycle's request |
| respErr | output | 1 | Request was rejected |
| respRdata | output | 64 | Read data, zero on error or write |
| tagSetValid | input | 1 | Recolor strobe |
| tagSetLine | input | LINE_IDX_BITS | Line to recolor |
| tagSetColor | input | 4 | New line color |
| trapClear | input | 1 | Clears the sticky trap flag |
| trapFlag | output | 1 | Sticky trap indicator |
| trapPtr | output | 64 | Captured faulting pointer |
| trapExpColor | output | 4 | Color of the faulting line |
| trapIsWrite | output | 1 | Faulting access was a write |
| trapCause | output | 2 | Fault cause code |

## Verification
The table walk exercises each access size at several offsets, with matching and mismatching colors and with reads and writes interleaved. This separates lane placement errors from failures in the color compare and the write suppression. A free-and-reallocate sequence recolors a line and then uses both the stale and the fresh color. This shows that the check depends on the line's current color and not on history. Pointers that combine several faults show whether the cause priority holds. A recolor issued in the same cycle as an access shows the boundary at which a color change takes effect. A clear issued in the same cycle as a fault shows whether the sticky flag logic resolves the two correctly.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int COLOR_BITS = 4;
  localparam int LINE_BYTES = 64;
  localparam int OFFSET_BITS = 6;
  localparam int PTR_BITS = 64;
  localparam int DATA_BYTES = 8;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_COLOR = 2'd1,
    CAUSE_FORM  = 2'd2,
    CAUSE_ALIGN = 2'd3
  } faultCause_t;

  typedef struct packed {
    logic        memWrite;
    logic        respLoad;
    logic        fault;
    logic        trapLoad;
    faultCause_t cause;
  } ctrlStrobe_t;
endpackage

// File: rtl/tagchk_ctrl.sv
module tagchk_ctrl
  import tagchk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tagEnable,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqSize,
  input  logic [COLOR_BITS-1:0]  ptrColor,
  input  logic [OFFSET_BITS-1:0] lineOffset,
  input  logic [COLOR_BITS-1:0]  lineColor,
  input  logic                   trapClear,
  output ctrlStrobe_t            strobe,
  output logic                   respValid,
  output logic                   respErr,
  output logic                   trapFlag
);
  localparam int SUM_BITS = OFFSET_BITS + 1;

  logic [3:0] nBytes;
  logic       crossErr;
  logic       formErr;
  logic       colorErr;
  faultCause_t cause;
  logic       fault;

  always_comb begin
    nBytes   = 4'd1 << reqSize;
    crossErr = (SUM_BITS'(lineOffset) + SUM_BITS'(nBytes)) > SUM_BITS'(LINE_BYTES);
    formErr  = !tagEnable && !((ptrColor == '0) || (ptrColor == '1));
    colorErr = tagEnable && (ptrColor != lineColor);
    if (formErr)       cause = CAUSE_FORM;
    else if (crossErr) cause = CAUSE_ALIGN;
    else if (colorErr) cause = CAUSE_COLOR;
    else               cause = CAUSE_NONE;
    fault = reqValid && (cause != CAUSE_NONE);

    strobe.memWrite = reqValid && reqWrite && !fault;
    strobe.respLoad = reqValid;
    strobe.fault    = fault;
    strobe.trapLoad = fault && (!trapFlag || trapClear);
    strobe.cause    = cause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respErr   <= 1'b0;
      trapFlag  <= 1'b0;
    end else begin
      respValid <= reqValid;
      respErr   <= fault;
      if (fault)          trapFlag <= 1'b1;
      else if (trapClear) trapFlag <= 1'b0;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_COLOR_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tagEnable && ptrColor != lineColor) |=> (respErr && trapFlag)); // R3
  AST_FORM_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !tagEnable && ptrColor != '0 && ptrColor != '1) |=> respErr); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trapFlag && !trapClear) |=> trapFlag); // R9
endmodule

// File: rtl/tagchk_dpath.sv
module tagchk_dpath
  import tagchk_pkg::*;
#(
  parameter int LINE_IDX_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic                     reqWrite,
  input  logic [1:0]               reqSize,
  input  logic [PTR_BITS-1:0]      reqPtr,
  input  logic [PTR_BITS-1:0]      reqWdata,
  input  logic                     tagSetValid,
  input  logic [LINE_IDX_BITS-1:0] tagSetLine,
  input  logic [COLOR_BITS-1:0]    tagSetColor,
  output logic [COLOR_BITS-1:0]    lineColor,
  output logic [PTR_BITS-1:0]      respRdata,
  output logic [PTR_BITS-1:0]      trapPtr,
  output logic [COLOR_BITS-1:0]    trapExpColor,
  output logic                     trapIsWrite,
  output logic [1:0]               trapCause
);
  localparam int NUM_LINES = 1 << LINE_IDX_BITS;
  localparam int MEM_ADDR_BITS = LINE_IDX_BITS + OFFSET_BITS;
  localparam int MEM_BYTES = 1 << MEM_ADDR_BITS;

  logic [7:0]              memBytes [MEM_BYTES];
  logic [COLOR_BITS-1:0]   tagColors [NUM_LINES];
  logic [LINE_IDX_BITS-1:0] lineIdx;
  logic [MEM_ADDR_BITS-1:0] byteBase;
  logic [3:0]              nBytes;
  logic [PTR_BITS-1:0]     readVal;

  assign lineIdx   = reqPtr[MEM_ADDR_BITS-1:OFFSET_BITS];
  assign byteBase  = reqPtr[MEM_ADDR_BITS-1:0];
  assign nBytes    = 4'd1 << reqSize;
  assign lineColor = tagColors[lineIdx];

  always_comb begin
    readVal = '0;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (4'(k) < nBytes)
        readVal[8*k +: 8] = memBytes[byteBase + MEM_ADDR_BITS'(k)];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (strobe.memWrite && (4'(k) < nBytes))
        memBytes[byteBase + MEM_ADDR_BITS'(k)] <= reqWdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) tagColors[i] <= '0;
    end else if (tagSetValid) begin
      tagColors[tagSetLine] <= tagSetColor;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respRdata    <= '0;
      trapPtr      <= '0;
      trapExpColor <= '0;
      trapIsWrite  <= 1'b0;
      trapCause    <= 2'd0;
    end else begin
      if (strobe.respLoad)
        respRdata <= (strobe.fault || reqWrite) ? '0 : readVal;
      if (strobe.trapLoad) begin
        trapPtr      <= reqPtr;
        trapExpColor <= lineColor;
        trapIsWrite  <= reqWrite;
        trapCause    <= strobe.cause;
      end
    end
  end

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |-> !strobe.memWrite); // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fault |=> (respRdata == '0)); // R3
  AST_TAG_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    tagSetValid |=> (tagColors[$past(tagSetLine)] == $past(tagSetColor))); // R7
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tagchk_pkg::*;
#(
  parameter int LINE_IDX_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tagEnable,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [1:0]               reqSize,
  input  logic [63:0]              reqPtr,
  input  logic [63:0]              reqWdata,
  output logic                     respValid,
  output logic                     respErr,
  output logic [63:0]              respRdata,
  input  logic                     tagSetValid,
  input  logic [LINE_IDX_BITS-1:0] tagSetLine,
  input  logic [3:0]               tagSetColor,
  input  logic                     trapClear,
  output logic                     trapFlag,
  output logic [63:0]              trapPtr,
  output logic [3:0]               trapExpColor,
  output logic                     trapIsWrite,
  output logic [1:0]               trapCause
);
  ctrlStrobe_t           strobe;
  logic [COLOR_BITS-1:0] lineColor;

  tagchk_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tagEnable  (tagEnable),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .ptrColor   (reqPtr[PTR_BITS-1 -: COLOR_BITS]),
    .lineOffset (reqPtr[OFFSET_BITS-1:0]),
    .lineColor  (lineColor),
    .trapClear  (trapClear),
    .strobe     (strobe),
    .respValid  (respValid),
    .respErr    (respErr),
    .trapFlag   (trapFlag)
  );

  tagchk_dpath #(.LINE_IDX_BITS(LINE_IDX_BITS)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .reqPtr       (reqPtr),
    .reqWdata     (reqWdata),
    .tagSetValid  (tagSetValid),
    .tagSetLine   (tagSetLine),
    .tagSetColor  (tagSetColor),
    .lineColor    (lineColor),
    .respRdata    (respRdata),
    .trapPtr      (trapPtr),
    .trapExpColor (trapExpColor),
    .trapIsWrite  (trapIsWrite),
    .trapCause    (trapCause)
  );

  AST_ERR_MEANS_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> trapFlag); // R9
endmodule

// File: tb/tb_tag_check_unit.sv
`timescale 1ns/1ps
module tb_tag_check_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tagEnable = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [63:0] reqPtr = '0;
  logic [63:0] reqWdata = '0;
  logic        respValid, respErr;
  logic [63:0] respRdata;
  logic        tagSetValid = 1'b0;
  logic [3:0]  tagSetLine = '0;
  logic [3:0]  tagSetColor = '0;
  logic        trapClear = 1'b0;
  logic        trapFlag;
  logic [63:0] trapPtr;
  logic [3:0]  trapExpColor;
  logic        trapIsWrite;
  logic [1:0]  trapCause;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tag_check_unit #(.LINE_IDX_BITS(4)) dut (
    .clk(clk), .rstN(rstN), .tagEnable(tagEnable),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqPtr(reqPtr), .reqWdata(reqWdata),
    .respValid(respValid), .respErr(respErr), .respRdata(respRdata),
    .tagSetValid(tagSetValid), .tagSetLine(tagSetLine), .tagSetColor(tagSetColor),
    .trapClear(trapClear), .trapFlag(trapFlag), .trapPtr(trapPtr),
    .trapExpColor(trapExpColor), .trapIsWrite(trapIsWrite), .trapCause(trapCause)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic [63:0] ptr;
    logic [63:0] wdata;
    logic        err;
    logic [63:0] rdata;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd3, 64'h3000_0000_0000_0040, 64'h1122334455667788, 1'b0, 64'h0},
    '{1'b0, 2'd3, 64'h3000_0000_0000_0040, 64'h0, 1'b0, 64'h1122334455667788},
    '{1'b0, 2'd0, 64'h3000_0000_0000_0043, 64'h0, 1'b0, 64'h55},
    '{1'b0, 2'd1, 64'h3000_0000_0000_0042, 64'h0, 1'b0, 64'h5566},
    '{1'b0, 2'd2, 64'h3000_0000_0000_0044, 64'h0, 1'b0, 64'h11223344},
    '{1'b1, 2'd0, 64'h3000_0000_0000_0041, 64'hAB, 1'b0, 64'h0},
    '{1'b0, 2'd3, 64'h3000_0000_0000_0040, 64'h0, 1'b0, 64'h112233445566AB88},
    '{1'b1, 2'd3, 64'h5000_0000_0000_0040, 64'h0, 1'b1, 64'h0},
    '{1'b0, 2'd3, 64'h3000_0000_0000_0040, 64'h0, 1'b0, 64'h112233445566AB88},
    '{1'b0, 2'd3, 64'h5000_0000_0000_0040, 64'h0, 1'b1, 64'h0},
    '{1'b1, 2'd2, 64'h5000_0000_0000_0080, 64'hDEADBEEF, 1'b0, 64'h0},
    '{1'b0, 2'd2, 64'h5000_0000_0000_0080, 64'h0, 1'b0, 64'hDEADBEEF},
    '{1'b0, 2'd3, 64'h3000_0000_0000_007C, 64'h0, 1'b1, 64'h0},
    '{1'b0, 2'd1, 64'h5000_0000_0000_00BF, 64'h0, 1'b1, 64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [63:0] p, input logic [63:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqPtr = p; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setTag(input logic [3:0] line, input logic [3:0] color);
    @(negedge clk);
    tagSetValid = 1'b1; tagSetLine = line; tagSetColor = color;
    @(negedge clk);
    tagSetValid = 1'b0;
  endtask

  task automatic clearTrap();
    @(negedge clk);
    trapClear = 1'b1;
    @(negedge clk);
    trapClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R2 reset respValid", {63'b0, respValid}, 64'd0);
    chk("R9 reset trapFlag", {63'b0, trapFlag}, 64'd0);

    // R1: colors reset to 0, color bits excluded from address
    access(1'b1, 2'd3, 64'h0000_0000_0000_0000, 64'hCAFE);
    chk("R1 reset color 0 write", {63'b0, respErr}, 64'd0);
    access(1'b0, 2'd3, 64'h0000_0000_0000_0000, 64'h0);
    chk("R1 read back", respRdata, 64'hCAFE);

    setTag(4'd1, 4'd3);
    setTag(4'd2, 4'd5);

    // table walk: R2 R3 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].size, VECS[i].ptr, VECS[i].wdata);
      chk($sformatf("R2 vec%0d valid", i), {63'b0, respValid}, 64'd1);
      chk($sformatf("R3 R5 vec%0d err", i), {63'b0, respErr}, {63'b0, VECS[i].err});
      chk($sformatf("R6 R10 vec%0d data", i), respRdata, VECS[i].rdata);
    end
    chk("R9 flag after table faults", {63'b0, trapFlag}, 64'd1);
    clearTrap();
    chk("R9 cleared", {63'b0, trapFlag}, 64'd0);

    // R7: recolor same cycle as access uses old color
    @(negedge clk);
    tagSetValid = 1'b1; tagSetLine = 4'd3; tagSetColor = 4'd7;
    reqValid = 1'b1; reqWrite = 1'b1; reqSize = 2'd3;
    reqPtr = 64'h7000_0000_0000_00C0; reqWdata = 64'h77;
    @(negedge clk);
    tagSetValid = 1'b0; reqValid = 1'b0;
    chk("R7 same-cycle sees old color", {63'b0, respErr}, 64'd1);
    clearTrap();
    access(1'b1, 2'd3, 64'h7000_0000_0000_00C0, 64'h77);
    chk("R7 next cycle new color", {63'b0, respErr}, 64'd0);
    access(1'b0, 2'd3, 64'h7000_0000_0000_00C0, 64'h0);
    chk("R7 read data", respRdata, 64'h77);

    // stale pointer after free and reallocate
    setTag(4'd4, 4'd2);
    access(1'b1, 2'd3, 64'h2000_0000_0000_0100, 64'hA5A5);
    chk("R2 write under color 2", {63'b0, respErr}, 64'd0);
    setTag(4'd4, 4'd9);
    access(1'b0, 2'd3, 64'h2000_0000_0000_0100, 64'h0);
    chk("R3 stale pointer traps", {63'b0, respErr}, 64'd1);
    chk("R3 stale read zero", respRdata, 64'd0);
    chk("R8 trapPtr", trapPtr, 64'h2000_0000_0000_0100);
    chk("R8 trapExpColor", {60'b0, trapExpColor}, 64'd9);
    chk("R8 trapCause color", {62'b0, trapCause}, 64'd1);
    chk("R8 trapIsWrite", {63'b0, trapIsWrite}, 64'd0);
    access(1'b0, 2'd3, 64'h9000_0000_0000_0100, 64'h0);
    chk("R3 new color succeeds", {63'b0, respErr}, 64'd0);
    chk("R10 data kept across recolor", respRdata, 64'hA5A5);

    // R8: later fault keeps first record
    access(1'b1, 2'd1, 64'h9000_0000_0000_013F, 64'h0);
    chk("R5 crossing write rejected", {63'b0, respErr}, 64'd1);
    chk("R8 first cause kept", {62'b0, trapCause}, 64'd1);
    chk("R8 first ptr kept", trapPtr, 64'h2000_0000_0000_0100);

    // R9: clear and fault same cycle
    clearTrap();
    chk("R9 clear", {63'b0, trapFlag}, 64'd0);
    @(negedge clk);
    trapClear = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd3;
    reqPtr = 64'h9000_0000_0000_013F;
    @(negedge clk);
    trapClear = 1'b0; reqValid = 1'b0;
    chk("R9 fault beats clear", {63'b0, trapFlag}, 64'd1);
    chk("R9 captured cause align", {62'b0, trapCause}, 64'd3);
    clearTrap();

    // R4: plain mode
    tagEnable = 1'b0;
    access(1'b0, 2'd3, 64'hF000_0000_0000_0040, 64'h0);
    chk("R4 top F accepted", {63'b0, respErr}, 64'd0);
    chk("R4 top F data", respRdata, 64'h112233445566AB88);
    access(1'b0, 2'd3, 64'h0000_0000_0000_0040, 64'h0);
    chk("R4 top 0 accepted", {63'b0, respErr}, 64'd0);
    access(1'b0, 2'd3, 64'h6000_0000_0000_0040, 64'h0);
    chk("R4 top 6 rejected", {63'b0, respErr}, 64'd1);
    chk("R4 cause form", {62'b0, trapCause}, 64'd2);

    // R11 priority
    clearTrap();
    access(1'b0, 2'd3, 64'h5000_0000_0000_007C, 64'h0);
    chk("R11 form over crossing", {62'b0, trapCause}, 64'd2);
    clearTrap();
    tagEnable = 1'b1;
    access(1'b1, 2'd3, 64'h5000_0000_0000_007C, 64'h0);
    chk("R11 crossing over color", {62'b0, trapCause}, 64'd3);
    chk("R11 expColor", {60'b0, trapExpColor}, 64'd3);
    chk("R11 isWrite", {63'b0, trapIsWrite}, 64'd1);

    finishRun();
  end
endmodule